// File: doc/BRIEF.md
# Descriptor Ring Pointer Register Bank

This block holds the index registers for a set of channels. Each channel pairs a request ring with a response ring, and both rings live in host memory. On every channel the host moves two indexes forward: the request tail, to post work, and the response head, to free entries it has handled. The device side moves the other two: the request head, as it takes work, and the response tail, as it writes completions. The host reaches all four registers through a simple read/write bus. Each channel occupies its own 4 KB window of that address space.

The device side names one channel at a time and gives it consume and produce strobes. For that channel the block returns empty and full flags. It also returns two memory addresses: where the next request entry will be read, and where the next response entry will be written. Each channel has its own memory chunk. The request ring starts at the bottom of the chunk and the response ring fills its top. The interrupt logic keeps interrupt traffic low. A channel's interrupt pulses only when its response ring stops being empty. The one exception is a completion that carries a force flag, which always raises it.

Top module: `ring_ptr_bank`

## Requirements
- R1: After reset every index register of every channel reads zero, and `irq_o`, `overflow_o` and `host_rdata_o` are all zero.
- R2: Channel c is decoded at byte address c*0x1000. Inside the window the offsets are 0x0 request head, 0x4 request tail, 0x8 response head and 0xC response tail. Read data appears on `host_rdata_o` one cycle after `host_rd_i`, zero-extended, and is zero in any cycle that follows no read.
- R3: A read of any other offset inside a window returns zero.
- R4: A host write to the request tail or the response head stores the value modulo DEPTH (its low log2(DEPTH) bits). A host write to the request head or the response tail has no effect.
- R5: `dev_consume_i` advances the selected channel's request head by one, modulo DEPTH, when the ring is not empty. The ring is empty when head equals tail, which is shown on `dev_req_empty_o`. A consume on an empty ring is ignored.
- R6: `dev_produce_i` advances the selected channel's response tail by one, modulo DEPTH, when the ring is not full. The ring is full when (tail+1) mod DEPTH equals head, which is shown on `dev_rsp_full_o`.
- R7: A produce on a full response ring is dropped: the tail is unchanged and no interrupt is raised. It sets that channel's bit of `overflow_o`, which then stays set until reset.
- R8: An accepted produce on an empty response ring pulses that channel's `irq_o` bit for exactly one cycle, in the cycle after the strobe. An accepted produce on a non-empty ring raises no interrupt.
- R9: An accepted produce with `dev_force_irq_i` high pulses the interrupt even when the response ring was not empty.
- R10: `dev_req_addr_o` equals `dev_base_i` + request head × REQ_BYTES for the selected channel.
- R11: `dev_rsp_addr_o` equals `dev_base_i` + `dev_len_i` − DEPTH × RSP_BYTES + response tail × RSP_BYTES for the selected channel.
- R12: Host and device operations on one channel leave the registers, interrupt and overflow bits of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| host_wr_i | input | 1 | Host write strobe |
| host_rd_i | input | 1 | Host read strobe |
| host_addr_i | input | 12+log2(NUM_CH) | Host byte address |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data, one cycle after the read |
| dev_ch_i | input | log2(NUM_CH) | Device-side channel select |
| dev_consume_i | input | 1 | Device took one request entry |
| dev_produce_i | input | 1 | Device wrote one response entry |
| dev_force_irq_i | input | 1 | Force an interrupt with this produce |
| dev_base_i | input | 64 | Memory chunk base of the selected channel |
| dev_len_i | input | 32 | Memory chunk length in bytes |
| dev_req_addr_o | output | 64 | Address of the next request entry |
| dev_rsp_addr_o | output | 64 | Address of the next response slot |
| dev_req_empty_o | output | 1 | Selected request ring is empty |
| dev_rsp_full_o | output | 1 | Selected response ring is full |
| irq_o | output | NUM_CH | Per-channel interrupt pulses |
| overflow_o | output | NUM_CH | Per-channel sticky overflow flags |

## Verification
The bench sweeps every channel of a four-channel, depth-eight bank. On each channel it drains a request ring across the index wrap and fills a response ring until it is full, then pushes one more entry. A wrong wrap or full test would either lose an entry or overwrite one the host had not yet read; the last push checks that the overflow flag is set and the tail stays put. A wrong interrupt condition would either pulse on every completion or miss the first one after the host has drained the ring, so each completion's pulse is checked against the modelled empty state, and the forced pulse is checked as well. Host writes to the read-only indexes, oversized write values, and reads of unused offsets are each checked by reading back, as are the neighbouring channels, which shows a decode error that hits the wrong window.

// File: rtl/ring_ptr_pkg.sv
package ring_ptr_pkg;

    localparam int unsigned WIN_BITS = 12;

    localparam logic [WIN_BITS-1:0] OFF_RQ_HEAD = 12'h000;
    localparam logic [WIN_BITS-1:0] OFF_RQ_TAIL = 12'h004;
    localparam logic [WIN_BITS-1:0] OFF_RS_HEAD = 12'h008;
    localparam logic [WIN_BITS-1:0] OFF_RS_TAIL = 12'h00C;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RQ_HEAD,
        SEL_RQ_TAIL,
        SEL_RS_HEAD,
        SEL_RS_TAIL
    } reg_sel_e;

    function automatic reg_sel_e decode_off(input logic [WIN_BITS-1:0] off);
        case (off)
            OFF_RQ_HEAD: return SEL_RQ_HEAD;
            OFF_RQ_TAIL: return SEL_RQ_TAIL;
            OFF_RS_HEAD: return SEL_RS_HEAD;
            OFF_RS_TAIL: return SEL_RS_TAIL;
            default:     return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/ring_ch.sv
module ring_ch #(
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_rq_tail_i,
    input  logic             wr_rs_head_i,
    input  logic [IDX_W-1:0] wdata_i,
    input  logic             consume_i,
    input  logic             produce_i,
    input  logic             force_i,
    output logic [IDX_W-1:0] rq_head_o,
    output logic [IDX_W-1:0] rq_tail_o,
    output logic [IDX_W-1:0] rs_head_o,
    output logic [IDX_W-1:0] rs_tail_o,
    output logic             rq_empty_o,
    output logic             rs_full_o,
    output logic             irq_o,
    output logic             ovf_o
);

    typedef struct packed {
        logic [IDX_W-1:0] rq_head;
        logic [IDX_W-1:0] rq_tail;
        logic [IDX_W-1:0] rs_head;
        logic [IDX_W-1:0] rs_tail;
        logic             irq;
        logic             ovf;
    } ch_state_t;

    ch_state_t        st_d, st_q;
    logic [IDX_W-1:0] rs_tail_inc;
    logic             rs_empty;

    always_comb begin
        rs_tail_inc = st_q.rs_tail + 1'b1;
        rs_empty    = (st_q.rs_tail == st_q.rs_head);
        rq_empty_o  = (st_q.rq_head == st_q.rq_tail);
        rs_full_o   = (rs_tail_inc == st_q.rs_head);

        st_d     = st_q;
        st_d.irq = 1'b0;
        if (wr_rq_tail_i) st_d.rq_tail = wdata_i;
        if (wr_rs_head_i) st_d.rs_head = wdata_i;
        if (consume_i && !rq_empty_o) st_d.rq_head = st_q.rq_head + 1'b1;
        if (produce_i) begin
            if (rs_full_o) begin
                st_d.ovf = 1'b1;
            end else begin
                st_d.rs_tail = rs_tail_inc;
                st_d.irq     = rs_empty || force_i;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign rq_head_o = st_q.rq_head;
    assign rq_tail_o = st_q.rq_tail;
    assign rs_head_o = st_q.rs_head;
    assign rs_tail_o = st_q.rs_tail;
    assign irq_o     = st_q.irq;
    assign ovf_o     = st_q.ovf;

endmodule

// File: rtl/ring_addr_gen.sv
module ring_addr_gen #(
    parameter int unsigned IDX_W     = 4,
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned REQ_BYTES = 64,
    parameter int unsigned RSP_BYTES = 4
) (
    input  logic [63:0]      base_i,
    input  logic [31:0]      len_i,
    input  logic [IDX_W-1:0] rq_head_i,
    input  logic [IDX_W-1:0] rs_tail_i,
    output logic [63:0]      rq_addr_o,
    output logic [63:0]      rs_addr_o
);

    localparam logic [63:0] RS_RING_BYTES = 64'(DEPTH * RSP_BYTES);
    localparam logic [63:0] RQ_STRIDE     = 64'(REQ_BYTES);
    localparam logic [63:0] RS_STRIDE     = 64'(RSP_BYTES);

    always_comb begin
        rq_addr_o = base_i + 64'(rq_head_i) * RQ_STRIDE;
        rs_addr_o = base_i + 64'(len_i) - RS_RING_BYTES + 64'(rs_tail_i) * RS_STRIDE;
    end

endmodule

// File: rtl/ring_ptr_bank.sv
module ring_ptr_bank
    import ring_ptr_pkg::*;
#(
    parameter int unsigned NUM_CH    = 16,
    parameter int unsigned DEPTH     = 16,
    parameter int unsigned REQ_BYTES = 64,
    parameter int unsigned RSP_BYTES = 4,
    localparam int unsigned CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned ADDR_W   = WIN_BITS + CH_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              host_wr_i,
    input  logic              host_rd_i,
    input  logic [ADDR_W-1:0] host_addr_i,
    input  logic [31:0]       host_wdata_i,
    output logic [31:0]       host_rdata_o,
    input  logic [CH_W-1:0]   dev_ch_i,
    input  logic              dev_consume_i,
    input  logic              dev_produce_i,
    input  logic              dev_force_irq_i,
    input  logic [63:0]       dev_base_i,
    input  logic [31:0]       dev_len_i,
    output logic [63:0]       dev_req_addr_o,
    output logic [63:0]       dev_rsp_addr_o,
    output logic              dev_req_empty_o,
    output logic              dev_rsp_full_o,
    output logic [NUM_CH-1:0] irq_o,
    output logic [NUM_CH-1:0] overflow_o
);

    typedef struct packed {
        logic [31:0] rdata;
    } bus_state_t;

    bus_state_t       bus_d, bus_q;
    logic [CH_W-1:0]  host_ch;
    reg_sel_e         host_sel;
    logic             unused_wdata_hi;

    logic [IDX_W-1:0] rq_head_a [NUM_CH];
    logic [IDX_W-1:0] rq_tail_a [NUM_CH];
    logic [IDX_W-1:0] rs_head_a [NUM_CH];
    logic [IDX_W-1:0] rs_tail_a [NUM_CH];
    logic [NUM_CH-1:0] rq_empty_a;
    logic [NUM_CH-1:0] rs_full_a;

    assign host_ch         = host_addr_i[ADDR_W-1:WIN_BITS];
    assign host_sel        = decode_off(host_addr_i[WIN_BITS-1:0]);
    assign unused_wdata_hi = ^host_wdata_i[31:IDX_W];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit, dev_hit;
        assign hit     = (host_ch == CH_W'(c));
        assign dev_hit = (dev_ch_i == CH_W'(c));

        ring_ch #(.IDX_W(IDX_W)) u_ch (
            .clk_i        (clk_i),
            .rst_ni       (rst_ni),
            .wr_rq_tail_i (host_wr_i && hit && (host_sel == SEL_RQ_TAIL)),
            .wr_rs_head_i (host_wr_i && hit && (host_sel == SEL_RS_HEAD)),
            .wdata_i      (host_wdata_i[IDX_W-1:0]),
            .consume_i    (dev_consume_i && dev_hit),
            .produce_i    (dev_produce_i && dev_hit),
            .force_i      (dev_force_irq_i),
            .rq_head_o    (rq_head_a[c]),
            .rq_tail_o    (rq_tail_a[c]),
            .rs_head_o    (rs_head_a[c]),
            .rs_tail_o    (rs_tail_a[c]),
            .rq_empty_o   (rq_empty_a[c]),
            .rs_full_o    (rs_full_a[c]),
            .irq_o        (irq_o[c]),
            .ovf_o        (overflow_o[c])
        );
    end

    ring_addr_gen #(
        .IDX_W     (IDX_W),
        .DEPTH     (DEPTH),
        .REQ_BYTES (REQ_BYTES),
        .RSP_BYTES (RSP_BYTES)
    ) u_addr (
        .base_i    (dev_base_i),
        .len_i     (dev_len_i),
        .rq_head_i (rq_head_a[dev_ch_i]),
        .rs_tail_i (rs_tail_a[dev_ch_i]),
        .rq_addr_o (dev_req_addr_o),
        .rs_addr_o (dev_rsp_addr_o)
    );

    assign dev_req_empty_o = rq_empty_a[dev_ch_i];
    assign dev_rsp_full_o  = rs_full_a[dev_ch_i];

    always_comb begin
        bus_d = '0;
        if (host_rd_i) begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (host_ch == CH_W'(c)) begin
                    case (host_sel)
                        SEL_RQ_HEAD: bus_d.rdata = 32'(rq_head_a[c]);
                        SEL_RQ_TAIL: bus_d.rdata = 32'(rq_tail_a[c]);
                        SEL_RS_HEAD: bus_d.rdata = 32'(rs_head_a[c]);
                        SEL_RS_TAIL: bus_d.rdata = 32'(rs_tail_a[c]);
                        default:     bus_d.rdata = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) bus_q <= '0;
        else         bus_q <= bus_d;
    end

    assign host_rdata_o = bus_q.rdata;

endmodule

// File: rtl/ring_ptr_bank_chk.sv
module ring_ptr_bank_chk #(
    parameter int unsigned NUM_CH = 16,
    parameter int unsigned CH_W   = 4,
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              host_rd_i,
    input logic [ADDR_W-1:0] host_addr_i,
    input logic [31:0]       host_rdata_o,
    input logic [CH_W-1:0]   dev_ch_i,
    input logic              dev_produce_i,
    input logic              dev_rsp_full_o,
    input logic [NUM_CH-1:0] irq_o,
    input logic [NUM_CH-1:0] overflow_o
);

    logic unused_off;
    assign unused_off = host_addr_i[1:0] != 2'b00;

    // R2: idle cycles leave the read bus at zero
    a_r2_idle_rdata_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !host_rd_i |=> host_rdata_o == 32'd0);

    // R3: unused offsets read as zero
    a_r3_unused_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_rd_i && (host_addr_i[11:4] != 8'd0 || unused_off)) |=> host_rdata_o == 32'd0);

    // R7: a produce on a full ring marks overflow on that channel
    a_r7_full_sets_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dev_produce_i && dev_rsp_full_o) |=> overflow_o[$past(dev_ch_i)]);

    // R7: overflow never clears while out of reset
    a_r7_overflow_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (overflow_o & $past(overflow_o)) == $past(overflow_o));

    // R8: one channel interrupts at a time, and only after a produce
    a_r8_irq_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(irq_o));

    a_r8_irq_needs_produce: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|irq_o) |-> $past(dev_produce_i));

    // R7: a dropped produce raises no interrupt
    a_r7_drop_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dev_produce_i && dev_rsp_full_o) |=> irq_o == '0);

endmodule

bind ring_ptr_bank ring_ptr_bank_chk #(
    .NUM_CH (NUM_CH),
    .CH_W   (CH_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .host_rd_i      (host_rd_i),
    .host_addr_i    (host_addr_i),
    .host_rdata_o   (host_rdata_o),
    .dev_ch_i       (dev_ch_i),
    .dev_produce_i  (dev_produce_i),
    .dev_rsp_full_o (dev_rsp_full_o),
    .irq_o          (irq_o),
    .overflow_o     (overflow_o)
);

// File: tb/ring_ptr_bank_tb.sv
module ring_ptr_bank_tb_top;

    localparam int NCH   = 4;
    localparam int DEP   = 8;
    localparam int RQB   = 64;
    localparam int RSB   = 4;
    localparam int CHW   = 2;
    localparam int AW    = 12 + CHW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0, host_rd = 1'b0;
    logic [AW-1:0] host_addr = '0;
    logic [31:0]   host_wdata = '0;
    logic [31:0]   host_rdata;
    logic [CHW-1:0] dev_ch = '0;
    logic          dev_consume = 1'b0, dev_produce = 1'b0, dev_force = 1'b0;
    logic [63:0]   dev_base = '0;
    logic [31:0]   dev_len = 32'h2000;
    logic [63:0]   req_addr, rsp_addr;
    logic          req_empty, rsp_full;
    logic [NCH-1:0] irq, ovf;

    int total = 0;
    int bad   = 0;

    int mrqh [NCH];
    int mrqt [NCH];
    int mrsh [NCH];
    int mrst [NCH];
    logic [NCH-1:0] movf = '0;

    always #2 clk = ~clk;

    ring_ptr_bank #(.NUM_CH(NCH), .DEPTH(DEP), .REQ_BYTES(RQB), .RSP_BYTES(RSB)) dut_i (
        .clk_i(clk), .rst_ni(rst_n),
        .host_wr_i(host_wr), .host_rd_i(host_rd), .host_addr_i(host_addr),
        .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
        .dev_ch_i(dev_ch), .dev_consume_i(dev_consume), .dev_produce_i(dev_produce),
        .dev_force_irq_i(dev_force), .dev_base_i(dev_base), .dev_len_i(dev_len),
        .dev_req_addr_o(req_addr), .dev_rsp_addr_o(rsp_addr),
        .dev_req_empty_o(req_empty), .dev_rsp_full_o(rsp_full),
        .irq_o(irq), .overflow_o(ovf)
    );

    task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got=%0h expected=%0h", tag, got, exp);
        end
    endtask

    function automatic logic [63:0] base_of(input int ch);
        return 64'h1_0000_0000 + 64'(ch) * 64'h10000;
    endfunction

    task automatic host_write(input int ch, input int off, input int val);
        @(negedge clk);
        host_wr = 1'b1;
        host_addr = AW'(ch * 4096 + off);
        host_wdata = 32'(val);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input int ch, input int off, input int exp, input string tag);
        @(negedge clk);
        host_rd = 1'b1;
        host_addr = AW'(ch * 4096 + off);
        @(posedge clk);
        #1;
        chk(tag, 64'(host_rdata), 64'(exp));
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic dev_op(input int ch, input bit c, input bit p, input bit f, output logic [NCH-1:0] irq_seen);
        @(negedge clk);
        dev_ch = CHW'(ch);
        dev_base = base_of(ch);
        dev_consume = c;
        dev_produce = p;
        dev_force = f;
        @(posedge clk);
        #1;
        irq_seen = irq;
        @(negedge clk);
        dev_consume = 1'b0;
        dev_produce = 1'b0;
        dev_force = 1'b0;
    endtask

    task automatic select(input int ch);
        @(negedge clk);
        dev_ch = CHW'(ch);
        dev_base = base_of(ch);
        #1;
    endtask

    task automatic read_all(input string tag);
        for (int c = 0; c < NCH; c++) begin
            host_read(c, 0,  mrqh[c], tag);
            host_read(c, 4,  mrqt[c], tag);
            host_read(c, 8,  mrsh[c], tag);
            host_read(c, 12, mrst[c], tag);
        end
    endtask

    initial begin
        #(4 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog: got=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [NCH-1:0] iq;
        bit was_empty;
        for (int c = 0; c < NCH; c++) begin
            mrqh[c] = 0; mrqt[c] = 0; mrsh[c] = 0; mrst[c] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 irq", 64'(irq), 0);
        chk("R1 overflow", 64'(ovf), 0);
        chk("R1 rdata", 64'(host_rdata), 0);
        read_all("R1 index after reset");

        for (int ch = 0; ch < NCH; ch++) begin
            // R4: tail write keeps low bits; oversized value wraps
            mrqt[ch] = (ch + 3) % DEP;
            host_write(ch, 4, 8 * 5 + mrqt[ch]);
            host_read(ch, 4, mrqt[ch], "R4 request tail masked");
            // R4: request head is read-only
            host_write(ch, 0, 5);
            host_read(ch, 0, mrqh[ch], "R4 request head ignores write");
            // R2 / R3: unused offsets
            host_read(ch, 16, 0, "R3 offset 0x10");
            host_read(ch, 12'hFFC, 0, "R3 offset 0xFFC");
            host_read(ch, 2, 0, "R3 offset 0x2");

            // R5 / R10: drain the request ring, then wrap it
            for (int round = 0; round < 2; round++) begin
                while (mrqh[ch] != mrqt[ch]) begin
                    select(ch);
                    chk("R10 request address", req_addr,
                        base_of(ch) + 64'(mrqh[ch]) * RQB);
                    chk("R5 not empty", 64'(req_empty), 0);
                    dev_op(ch, 1'b1, 1'b0, 1'b0, iq);
                    mrqh[ch] = (mrqh[ch] + 1) % DEP;
                end
                select(ch);
                chk("R5 empty flag", 64'(req_empty), 1);
                dev_op(ch, 1'b1, 1'b0, 1'b0, iq);
                host_read(ch, 0, mrqh[ch], "R5 consume on empty ignored");
                mrqt[ch] = (mrqh[ch] + DEP - 1) % DEP;
                host_write(ch, 4, mrqt[ch]);
            end

            // R6 / R8 / R9 / R11: fill the response ring
            for (int k = 0; k < DEP - 1; k++) begin
                select(ch);
                chk("R11 response address", rsp_addr,
                    base_of(ch) + 64'h2000 - 64'(DEP * RSB) + 64'(mrst[ch]) * RSB);
                chk("R6 not full", 64'(rsp_full), 0);
                was_empty = (mrsh[ch] == mrst[ch]);
                dev_op(ch, 1'b0, 1'b1, (k == 3), iq);
                mrst[ch] = (mrst[ch] + 1) % DEP;
                if (k == 3)
                    chk("R9 forced irq", 64'(iq), 64'(1) << ch);
                else
                    chk("R8 irq on empty edge only", 64'(iq), was_empty ? (64'(1) << ch) : 0);
                @(posedge clk);
                #1;
                chk("R8 irq one cycle", 64'(irq), 0);
            end
            select(ch);
            chk("R6 full flag", 64'(rsp_full), 1);
            // R7: push when full
            dev_op(ch, 1'b0, 1'b1, 1'b1, iq);
            movf[ch] = 1'b1;
            chk("R7 dropped produce no irq", 64'(iq), 0);
            chk("R7 overflow set", 64'(ovf), 64'(movf));
            host_read(ch, 12, mrst[ch], "R7 tail unchanged");
            // R4: response tail is read-only
            host_write(ch, 12, 1);
            host_read(ch, 12, mrst[ch], "R4 response tail ignores write");
            // host drains, then the next produce interrupts again
            mrsh[ch] = mrst[ch];
            host_write(ch, 8, mrsh[ch] + 16);
            host_read(ch, 8, mrsh[ch], "R4 response head masked");
            dev_op(ch, 1'b0, 1'b1, 1'b0, iq);
            mrst[ch] = (mrst[ch] + 1) % DEP;
            chk("R8 irq after drain", 64'(iq), 64'(1) << ch);
            chk("R7 overflow sticky", 64'(ovf), 64'(movf));
            // R12: other channels unaffected
            read_all("R12 channel isolation");
        end

        @(negedge clk);
        #1;
        chk("R2 rdata idle zero", 64'(host_rdata), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule